// File: doc/BRIEF.md
# Arbitrated Dual-Access Agent Memory

This block is an on-chip word store held inside a compute unit and reached from two sides. The unit's datapath uses a small set of internal load/store ports, each with a valid/stall handshake. An external host uses a separate memory-mapped agent port with its own address and data buses. That port is wider than one element, so one external word covers several consecutive elements. The storage has a single access slot per cycle. A fixed-priority arbiter gives that slot to the external port first and then to the internal ports in index order.

Two parameters shape the external port. The access mode selects read-write, read-only or write-only, and generate logic leaves out the external path that the mode does not use. The concurrency flag selects whether the host may access the store while the unit reports busy. When the flag is off, an access attempted while busy is refused and reported with an error pulse. The datapath can then rely on stable contents for the whole run.

Top module: `dual_access_agent_mem`

## Requirements
- R1: When an effective external access occurs in a cycle, every valid internal port sees int_stall high in that same cycle and does not access the store.
- R2: A stalled internal request, held stable, completes with correct data once external traffic stops, no matter how long it was starved; no memory word changes except by a granted write.
- R3: When no external access occurs, the lowest-indexed valid internal port is granted (int_stall low) and every other valid port is stalled.
- R4: A granted internal read raises the bit of int_rvalid for that port for exactly one cycle, in the cycle after the grant, with the element on int_rdata; a granted internal write stores int_wdata at its element address.
- R5: In read-only mode ext_wr is ignored: the store is unchanged, the request takes no slot, and an ext_rd asserted together with it is served as a read.
- R6: In write-only mode ext_rd is ignored: ext_rvalid stays low and ext_rdata reads zero.
- R7: In read-write mode an external write stores the word, and an external read returns it one cycle later with a one-cycle ext_rvalid pulse.
- R8: The external data bus is ELEM_W*WIDEN bits wide, and external word r covers elements r*WIDEN+k, with lane k at bits [k*ELEM_W +: ELEM_W].
- R9: With concurrency disabled and unit_busy high, an external access leaves the store unchanged, takes no slot, raises ext_err for one cycle in the next cycle, and gives no ext_rvalid.
- R10: With concurrency enabled, an external access made while unit_busy is high is served as normal, and ext_err stays low.
- R11: After reset, ext_rvalid, ext_err and int_rvalid are all low.
- R12: In read-write mode, when ext_rd and ext_wr are asserted together, only the write is performed and ext_rvalid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unit_busy | input | 1 | Compute unit running flag |
| ext_rd | input | 1 | External read request |
| ext_wr | input | 1 | External write request |
| ext_addr | input | EAW (4) | External word index |
| ext_wdata | input | EW (16) | External write data |
| ext_rdata | output | EW (16) | External read data, valid with ext_rvalid |
| ext_rvalid | output | 1 | External read data pulse |
| ext_err | output | 1 | Refused-access pulse |
| int_valid | input | N_INT (2) | Internal request valid, one bit per port |
| int_we | input | N_INT (2) | Internal write enable per port |
| int_addr | input | N_INT*AW (10) | Packed element addresses, port i at [i*AW +: AW] |
| int_wdata | input | N_INT*ELEM_W (16) | Packed write data, port i at [i*ELEM_W +: ELEM_W] |
| int_stall | output | N_INT (2) | Request not granted this cycle |
| int_rdata | output | ELEM_W (8) | Shared internal read data |
| int_rvalid | output | N_INT (2) | Read data pulse, naming the port it belongs to |

## Verification
The bench drives four instances from one stimulus stream: read-write, read-only, write-only, and read-write with concurrency. It goes after a starved internal read that is held through back-to-back host reads. A design that dropped or repeated that request would return stale data, or no rvalid at all. It also targets lane placement inside a wide external word, where a swapped lane shows up as a wrong byte on a later internal read, and simultaneous read and write strobes, where a design that served both would pulse ext_rvalid. Accesses refused while the unit is busy are checked too. A design that let them reach the store would change the model's contents, and one that let them take the slot would stall the internal port.

// File: rtl/agent_mem_pkg.sv
// Shared types for the dual-access agent memory.
package agent_mem_pkg;
    // External port access mode.
    typedef enum logic [1:0] {
        EXT_RW = 2'd0,
        EXT_RO = 2'd1,
        EXT_WO = 2'd2
    } ext_mode_e;
endpackage

// File: rtl/agent_mem_ext_gate.sv
// External request qualifier.
// Turns the raw host strobes into effective read/write requests according to
// the access mode, and refuses them while the unit is busy when concurrency is
// off. Assumes strobes are sampled once per cycle; a write outranks a read.
module agent_mem_ext_gate
    import agent_mem_pkg::*;
#(
    parameter ext_mode_e MODE       = EXT_RW,
    parameter bit        ALLOW_BUSY = 1'b0
) (
    input  logic ext_rd,
    input  logic ext_wr,
    input  logic unit_busy,
    output logic do_rd,
    output logic do_wr,
    output logic blocked
);
    logic rd_req;
    logic wr_req;

    // Mode selection: build only the request paths the mode permits.
    generate
        if (MODE == EXT_RO) begin : g_ro
            assign wr_req = 1'b0;
            assign rd_req = ext_rd;
        end else if (MODE == EXT_WO) begin : g_wo
            assign wr_req = ext_wr;
            assign rd_req = 1'b0;
        end else begin : g_rw
            assign wr_req = ext_wr;
            assign rd_req = ext_rd & ~ext_wr;
        end
    endgenerate

    // Busy interlock: present only when concurrent access is disallowed.
    generate
        if (ALLOW_BUSY) begin : g_conc
            assign blocked = 1'b0;
        end else begin : g_lock
            assign blocked = (rd_req | wr_req) & unit_busy;
        end
    endgenerate

    assign do_rd = rd_req & ~blocked;
    assign do_wr = wr_req & ~blocked;
endmodule

// File: rtl/agent_mem_prio.sv
// Fixed-priority slot arbiter.
// The external request takes the single slot first; otherwise the lowest
// indexed valid internal port wins. Assumes one store access per cycle.
module agent_mem_prio #(
    parameter int N_INT = 2
) (
    input  logic             ext_go,
    input  logic [N_INT-1:0] int_valid,
    output logic [N_INT-1:0] int_gnt
);
    logic taken;

    // Priority scan: external first, then ascending port index.
    always_comb begin
        int_gnt = '0;
        taken   = ext_go;
        for (int i = 0; i < N_INT; i++) begin
            if (int_valid[i] && !taken) begin
                int_gnt[i] = 1'b1;
                taken      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/agent_mem_store.sv
// Element storage with one write slot and registered reads.
// An external word spans WIDEN consecutive elements. Assumes the arbiter never
// asserts an external and an internal access in the same cycle, and that
// DEPTH is a multiple of WIDEN. Contents are not reset.
module agent_mem_store #(
    parameter int DEPTH      = 32,
    parameter int ELEM_W     = 8,
    parameter int WIDEN      = 2,
    parameter bit HAS_EXT_RD = 1'b1,
    localparam int AW  = $clog2(DEPTH),
    localparam int EAW = $clog2(DEPTH / WIDEN),
    localparam int EW  = ELEM_W * WIDEN
) (
    input  logic              clk,
    input  logic              ext_we,
    input  logic              ext_re,
    input  logic [EAW-1:0]    ext_row,
    input  logic [EW-1:0]     ext_wdata,
    input  logic              int_we,
    input  logic              int_re,
    input  logic [AW-1:0]     int_addr,
    input  logic [ELEM_W-1:0] int_wdata,
    output logic [EW-1:0]     ext_rdata,
    output logic [ELEM_W-1:0] int_rdata
);
    logic [ELEM_W-1:0] mem [DEPTH];

    // Write slot: an external word write or one internal element write.
    always_ff @(posedge clk) begin
        if (ext_we) begin
            for (int k = 0; k < WIDEN; k++) begin
                mem[AW'(int'(ext_row) * WIDEN + k)] <= ext_wdata[k*ELEM_W +: ELEM_W];
            end
        end else if (int_we) begin
            mem[int_addr] <= int_wdata;
        end
    end

    // Internal read register, one cycle of latency.
    always_ff @(posedge clk) begin
        if (int_re) begin
            int_rdata <= mem[int_addr];
        end
    end

    // External read register, built only when the mode has a read path.
    generate
        if (HAS_EXT_RD) begin : g_ext_rd
            always_ff @(posedge clk) begin
                if (ext_re) begin
                    for (int k = 0; k < WIDEN; k++) begin
                        ext_rdata[k*ELEM_W +: ELEM_W] <= mem[AW'(int'(ext_row) * WIDEN + k)];
                    end
                end
            end
        end else begin : g_no_ext_rd
            assign ext_rdata = '0;
        end
    endgenerate
endmodule

// File: rtl/dual_access_agent_mem.sv
// Dual-access agent memory top.
// Joins the external request gate, the priority arbiter and the storage, and
// registers the read-valid and error pulses. Assumes a stalled internal port
// keeps address, write data and write enable stable until granted.
module dual_access_agent_mem
    import agent_mem_pkg::*;
#(
    parameter int        DEPTH      = 32,
    parameter int        ELEM_W     = 8,
    parameter int        WIDEN      = 2,
    parameter int        N_INT      = 2,
    parameter ext_mode_e MODE       = EXT_RW,
    parameter bit        ALLOW_BUSY = 1'b0,
    localparam int AW  = $clog2(DEPTH),
    localparam int EAW = $clog2(DEPTH / WIDEN),
    localparam int EW  = ELEM_W * WIDEN
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    unit_busy,
    input  logic                    ext_rd,
    input  logic                    ext_wr,
    input  logic [EAW-1:0]          ext_addr,
    input  logic [EW-1:0]           ext_wdata,
    output logic [EW-1:0]           ext_rdata,
    output logic                    ext_rvalid,
    output logic                    ext_err,
    input  logic [N_INT-1:0]        int_valid,
    input  logic [N_INT-1:0]        int_we,
    input  logic [N_INT*AW-1:0]     int_addr,
    input  logic [N_INT*ELEM_W-1:0] int_wdata,
    output logic [N_INT-1:0]        int_stall,
    output logic [ELEM_W-1:0]       int_rdata,
    output logic [N_INT-1:0]        int_rvalid
);
    localparam bit HAS_RD = (MODE != EXT_WO);

    logic              do_rd;
    logic              do_wr;
    logic              blocked;
    logic              ext_go;
    logic [N_INT-1:0]  gnt;
    logic              sel_we;
    logic              sel_re;
    logic [AW-1:0]     sel_addr;
    logic [ELEM_W-1:0] sel_wdata;

    agent_mem_ext_gate #(.MODE(MODE), .ALLOW_BUSY(ALLOW_BUSY)) u_gate (
        .ext_rd    (ext_rd),
        .ext_wr    (ext_wr),
        .unit_busy (unit_busy),
        .do_rd     (do_rd),
        .do_wr     (do_wr),
        .blocked   (blocked)
    );

    assign ext_go = do_rd | do_wr;

    agent_mem_prio #(.N_INT(N_INT)) u_prio (
        .ext_go    (ext_go),
        .int_valid (int_valid),
        .int_gnt   (gnt)
    );

    assign int_stall = int_valid & ~gnt;

    // Winner mux: route the granted internal port's fields to the store.
    always_comb begin
        sel_addr  = '0;
        sel_wdata = '0;
        for (int i = 0; i < N_INT; i++) begin
            if (gnt[i]) begin
                sel_addr  = int_addr[i*AW +: AW];
                sel_wdata = int_wdata[i*ELEM_W +: ELEM_W];
            end
        end
    end

    assign sel_we = |(gnt & int_we);
    assign sel_re = |(gnt & ~int_we);

    agent_mem_store #(
        .DEPTH(DEPTH), .ELEM_W(ELEM_W), .WIDEN(WIDEN), .HAS_EXT_RD(HAS_RD)
    ) u_store (
        .clk       (clk),
        .ext_we    (do_wr),
        .ext_re    (do_rd),
        .ext_row   (ext_addr),
        .ext_wdata (ext_wdata),
        .int_we    (sel_we),
        .int_re    (sel_re),
        .int_addr  (sel_addr),
        .int_wdata (sel_wdata),
        .ext_rdata (ext_rdata),
        .int_rdata (int_rdata)
    );

    // Internal read-valid and external error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_rvalid <= '0;
            ext_err    <= 1'b0;
        end else begin
            int_rvalid <= gnt & ~int_we;
            ext_err    <= blocked;
        end
    end

    // External read-valid pulse, only where a read path exists.
    generate
        if (HAS_RD) begin : g_rv
            always_ff @(posedge clk) begin
                if (!rst_n) ext_rvalid <= 1'b0;
                else        ext_rvalid <= do_rd;
            end
        end else begin : g_no_rv
            assign ext_rvalid = 1'b0;
        end
    endgenerate

    // External access stalls every valid internal port.
    assert_ext_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ext_go |-> (int_stall == int_valid));

    // Without external traffic, port 0 is never stalled.
    assert_low_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (int_valid[0] && !ext_go) |-> !int_stall[0]);

    // At most one internal read pulse per cycle.
    assert_one_rvalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(int_rvalid));

    // A granted internal read yields a pulse next cycle.
    assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(int_valid & ~int_stall & ~int_we)) |=> (|int_rvalid));

    // A refused access reports an error and no read data.
    assert_refused_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> (ext_err && !ext_rvalid));

    // An external write never produces a read pulse.
    assert_wr_no_rvalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        do_wr |=> !ext_rvalid);
endmodule

// File: tb/dual_access_agent_mem_tb.sv
`timescale 1ns/1ps
// Bench: four instances (RW, RO, WO, RW+concurrent) share one stimulus stream
// and are compared each cycle against per-instance reference models.
module dual_access_agent_mem_tb;
    import agent_mem_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        unit_busy, ext_rd, ext_wr;
    logic [3:0]  ext_addr;
    logic [15:0] ext_wdata;
    logic [1:0]  int_valid, int_we;
    logic [9:0]  int_addr;
    logic [15:0] int_wdata;

    logic [15:0] e_rd [4];
    logic        e_rv [4];
    logic        e_er [4];
    logic [1:0]  i_st [4];
    logic [7:0]  i_rd [4];
    logic [1:0]  i_rv [4];

    ext_mode_e md [4] = '{EXT_RW, EXT_RO, EXT_WO, EXT_RW};
    bit        ab [4] = '{1'b0, 1'b0, 1'b0, 1'b1};

    logic [7:0]  mdl [4][32];
    bit          x_erv [4];
    bit          x_err [4];
    logic [15:0] x_erd [4];
    logic [1:0]  x_irv [4];
    logic [7:0]  x_ird [4];
    logic [1:0]  stall_any;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    dual_access_agent_mem #(.MODE(EXT_RW), .ALLOW_BUSY(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .unit_busy(unit_busy), .ext_rd(ext_rd), .ext_wr(ext_wr),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(e_rd[0]), .ext_rvalid(e_rv[0]),
        .ext_err(e_er[0]), .int_valid(int_valid), .int_we(int_we), .int_addr(int_addr),
        .int_wdata(int_wdata), .int_stall(i_st[0]), .int_rdata(i_rd[0]), .int_rvalid(i_rv[0]));
    dual_access_agent_mem #(.MODE(EXT_RO), .ALLOW_BUSY(1'b0)) u_dut_ro (
        .clk(clk), .rst_n(rst_n), .unit_busy(unit_busy), .ext_rd(ext_rd), .ext_wr(ext_wr),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(e_rd[1]), .ext_rvalid(e_rv[1]),
        .ext_err(e_er[1]), .int_valid(int_valid), .int_we(int_we), .int_addr(int_addr),
        .int_wdata(int_wdata), .int_stall(i_st[1]), .int_rdata(i_rd[1]), .int_rvalid(i_rv[1]));
    dual_access_agent_mem #(.MODE(EXT_WO), .ALLOW_BUSY(1'b0)) u_dut_wo (
        .clk(clk), .rst_n(rst_n), .unit_busy(unit_busy), .ext_rd(ext_rd), .ext_wr(ext_wr),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(e_rd[2]), .ext_rvalid(e_rv[2]),
        .ext_err(e_er[2]), .int_valid(int_valid), .int_we(int_we), .int_addr(int_addr),
        .int_wdata(int_wdata), .int_stall(i_st[2]), .int_rdata(i_rd[2]), .int_rvalid(i_rv[2]));
    dual_access_agent_mem #(.MODE(EXT_RW), .ALLOW_BUSY(1'b1)) u_dut_cc (
        .clk(clk), .rst_n(rst_n), .unit_busy(unit_busy), .ext_rd(ext_rd), .ext_wr(ext_wr),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(e_rd[3]), .ext_rvalid(e_rv[3]),
        .ext_err(e_er[3]), .int_valid(int_valid), .int_we(int_we), .int_addr(int_addr),
        .int_wdata(int_wdata), .int_stall(i_st[3]), .int_rdata(i_rd[3]), .int_rvalid(i_rv[3]));

    task automatic check(input bit ok, input string tag, input string what, input int d,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s dut%0d actual=%h expected=%h", tag, what, d, act, exp);
        end
    endtask

    task automatic idle();
        unit_busy = 1'b0; ext_rd = 1'b0; ext_wr = 1'b0; ext_addr = '0; ext_wdata = '0;
        int_valid = '0; int_we = '0; int_addr = '0; int_wdata = '0;
    endtask

    task automatic set_ext(input bit rd, input bit wr, input logic [3:0] a, input logic [15:0] wd);
        ext_rd = rd; ext_wr = wr; ext_addr = a; ext_wdata = wd;
    endtask

    task automatic set_int(input int i, input bit v, input bit we, input logic [4:0] a,
                           input logic [7:0] wd);
        int_valid[i] = v; int_we[i] = we; int_addr[i*5 +: 5] = a; int_wdata[i*8 +: 8] = wd;
    endtask

    // One cycle: check stalls, predict registered outputs, clock, check them.
    task automatic step(input string tag);
        #1;
        stall_any = '0;
        for (int d = 0; d < 4; d++) begin
            bit w, r, blk, go;
            int win;
            logic [1:0] est;
            logic [4:0] wa;
            w   = ext_wr && (md[d] != EXT_RO);
            r   = ext_rd && (md[d] != EXT_WO) && !w;
            blk = (w || r) && !ab[d] && unit_busy;
            go  = (w || r) && !blk;
            win = -1;
            if (!go) begin
                for (int i = 0; i < 2; i++) if (int_valid[i] && win < 0) win = i;
            end
            est = int_valid;
            if (win >= 0) est[win] = 1'b0;
            check(i_st[d] === est, tag, "int_stall", d, 32'(i_st[d]), 32'(est));
            stall_any |= i_st[d];
            x_erv[d] = go && r;
            x_err[d] = blk;
            if (go && r) x_erd[d] = {mdl[d][{ext_addr, 1'b1}], mdl[d][{ext_addr, 1'b0}]};
            x_irv[d] = '0;
            if (win >= 0) begin
                wa = int_addr[win*5 +: 5];
                if (int_we[win]) begin
                    if (!(go && w)) mdl[d][wa] = int_wdata[win*8 +: 8];
                end else begin
                    x_irv[d][win] = 1'b1;
                    x_ird[d] = mdl[d][wa];
                end
            end
            if (go && w) begin
                mdl[d][{ext_addr, 1'b0}] = ext_wdata[7:0];
                mdl[d][{ext_addr, 1'b1}] = ext_wdata[15:8];
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int d = 0; d < 4; d++) begin
            check(e_rv[d] === x_erv[d], tag, "ext_rvalid", d, 32'(e_rv[d]), 32'(x_erv[d]));
            check(e_er[d] === x_err[d], tag, "ext_err", d, 32'(e_er[d]), 32'(x_err[d]));
            check(i_rv[d] === x_irv[d], tag, "int_rvalid", d, 32'(i_rv[d]), 32'(x_irv[d]));
            if (x_erv[d]) check(e_rd[d] === x_erd[d], tag, "ext_rdata", d, 32'(e_rd[d]), 32'(x_erd[d]));
            if (|x_irv[d]) check(i_rd[d] === x_ird[d], tag, "int_rdata", d, 32'(i_rd[d]), 32'(x_ird[d]));
            if (md[d] == EXT_WO) check(e_rd[d] === 16'h0, "R6", "ext_rdata zero", d, 32'(e_rd[d]), 0);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        idle();
        repeat (4) @(negedge clk);
        for (int d = 0; d < 4; d++) begin   // R11 reset state
            check(e_rv[d] === 1'b0, "R11", "ext_rvalid", d, 32'(e_rv[d]), 0);
            check(e_er[d] === 1'b0, "R11", "ext_err", d, 32'(e_er[d]), 0);
            check(i_rv[d] === 2'b0, "R11", "int_rvalid", d, 32'(i_rv[d]), 0);
        end
        rst_n = 1'b1;
        for (int a = 0; a < 32; a++) begin   // preload through internal writes
            idle(); set_int(0, 1, 1, 5'(a), 8'(a * 7 + 3)); step("R4");
        end
        idle(); set_ext(0, 1, 4'd3, 16'hA55A); step("R7");
        idle(); set_ext(1, 0, 4'd3, 16'h0);    step("R7");
        idle(); set_ext(0, 1, 4'd2, 16'hBEEF); step("R8");
        idle(); set_int(0, 1, 0, 5'd4, 8'h0);  step("R8");
        idle(); set_int(0, 1, 0, 5'd5, 8'h0);  step("R8");
        idle(); set_ext(1, 1, 4'd6, 16'h1234); step("R12");
        idle(); set_ext(1, 0, 4'd6, 16'h0);    step("R12");
        idle(); set_ext(0, 1, 4'd7, 16'h7777);
        set_int(0, 1, 1, 5'd14, 8'h11); set_int(1, 1, 0, 5'd3, 8'h0); step("R1");
        set_ext(0, 0, 4'd0, 16'h0); step("R3");
        set_int(0, 0, 0, 5'd0, 8'h0); step("R3");
        idle(); set_int(0, 1, 0, 5'd9, 8'h0); set_int(1, 1, 0, 5'd10, 8'h0); step("R3");
        idle(); set_int(1, 1, 0, 5'd15, 8'h0);
        for (int k = 0; k < 6; k++) begin set_ext(1, 0, 4'(k), 16'h0); step("R2"); end
        set_ext(0, 0, 4'd0, 16'h0); step("R2");
        idle(); set_ext(0, 1, 4'd9, 16'hFFFF); set_int(0, 1, 0, 5'd18, 8'h0); step("R5");
        idle(); set_ext(1, 1, 4'd9, 16'h00FF); step("R5");
        idle(); set_int(0, 1, 0, 5'd19, 8'h0); step("R5");
        idle(); set_ext(1, 0, 4'd9, 16'h0); set_int(0, 1, 0, 5'd5, 8'h0); step("R6");
        idle(); unit_busy = 1'b1; set_ext(0, 1, 4'd10, 16'hCAFE);
        set_int(0, 1, 1, 5'd2, 8'h5A); step("R9");
        idle(); set_ext(1, 0, 4'd10, 16'h0); step("R9");
        idle(); unit_busy = 1'b1; set_ext(1, 0, 4'd10, 16'h0); step("R10");
        idle(); unit_busy = 1'b1; set_ext(0, 1, 4'd11, 16'h600D); step("R10");
        idle(); set_ext(1, 0, 4'd11, 16'h0); step("R10");
        idle(); stall_any = '0;
        for (int n = 0; n < 1500; n++) begin   // random traffic with held stalls
            unit_busy = ($urandom % 4) == 0;
            set_ext(($urandom % 3) == 0, ($urandom % 4) == 0, 4'($urandom), 16'($urandom));
            for (int i = 0; i < 2; i++) begin
                if (!stall_any[i])
                    set_int(i, ($urandom % 5) < 3, $urandom % 2, 5'($urandom), 8'($urandom));
            end
            step("R2");
        end
        idle(); step("R2");
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule